// File: doc/BRIEF.md
# Low-Power Wakeup Event Detector

This block watches three platform inputs while a low-power mode is enabled and raises a wake request when one of them shows a qualifying event. The inputs are a power button, a lid-open switch and an AC-present signal. A falling edge on the button counts as an event. So does a rising edge on the lid switch, or a high level on the AC input. Each input has its own debounce duration, given in clock cycles. An event is accepted only after the new level has been held for that duration. A pending interrupt from elsewhere in the controller can also wake the system.

Each input runs its own qualifier state machine. The states are:
- `ST_OFF`: mode disabled, counter and history cleared.
- `ST_IDLE`: armed and tracking the previous level.
- `ST_COUNT`: debouncing a candidate event.
- `ST_HOLD`: event accepted, waiting for the input to leave its active level.

The transitions are:
- OFF→IDLE when the mode is enabled. The current level is captured as history, so a level that is already present gives no edge.
- IDLE→COUNT when the trigger condition is seen.
- COUNT→IDLE when the input leaves its active level (a bounce).
- COUNT→HOLD when the counter reaches the programmed duration. This transition emits a one-cycle event.
- HOLD→IDLE when the input leaves its active level.
- Any state→OFF when the mode is disabled.

Accepted events set sticky status bits. Software clears these bits by writing 1 to them.

Top module: `lpwake_detect`

## Requirements
- R1: After reset, `lp_status_o` is 0, `wk_status_o` is 2'b00 and `wake_req_o` is 0.
- R2: With the mode enabled, a high-to-low change on `pwrb_i` that is held low sets `lp_status_o` and `wk_status_o[0]`. A low-to-high change on `pwrb_i` sets nothing.
- R3: With the mode enabled, a low-to-high change on `lid_i` that is held high sets `lp_status_o` and `wk_status_o[0]`.
- R4: With the mode enabled, `ac_i` held high sets `lp_status_o` and `wk_status_o[0]` once for each high period. It sets them again only after `ac_i` has gone low and then come back high.
- R5: When an input reaches its active level in the cycle before clock edge k, status is set at edge k+1+D, where D is that input's duration, and not earlier. If the input leaves its active level before then, the count is abandoned and restarts from zero on the next trigger.
- R6: Each input uses only its own duration (`pwrb_dbnc_i`, `lid_dbnc_i`, `ac_dbnc_i`).
- R7: While `lp_en_i` is 0, no input changes any status. When the mode is enabled, a level already present on an edge input does not count as an edge.
- R8: Clearing `lp_en_i` resets every qualifier counter and its edge history, and leaves both status outputs unchanged.
- R9: While the mode is enabled, `irq_pend_i` high sets `wk_status_o[1]` and leaves `lp_status_o` unchanged.
- R10: A 1 on `lp_clr_i` clears `lp_status_o`, and a 1 on bit n of `wk_clr_i` clears `wk_status_o[n]`, at the next edge. A set and a clear in the same cycle leave the bit set.
- R11: `wake_req_o` is the OR of the two `wk_status_o` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lp_en_i | input | 1 | Low-power mode enable |
| pwrb_i | input | 1 | Power button level (event on falling edge) |
| lid_i | input | 1 | Lid-open level (event on rising edge) |
| ac_i | input | 1 | AC-present level (event on high level) |
| pwrb_dbnc_i | input | CNT_W | Button debounce duration in cycles |
| lid_dbnc_i | input | CNT_W | Lid debounce duration in cycles |
| ac_dbnc_i | input | CNT_W | AC debounce duration in cycles |
| irq_pend_i | input | 1 | Pending interrupt from the controller |
| lp_clr_i | input | 1 | Write-1 clear for the low-power status |
| wk_clr_i | input | 2 | Write-1 clear per wakeup status bit |
| lp_status_o | output | 1 | Sticky flag: an input event was accepted |
| wk_status_o | output | 2 | Sticky wakeup causes: bit 0 input event, bit 1 interrupt |
| wake_req_o | output | 1 | Wake request |

## Verification
Each input is driven with its own polarity and with the opposite polarity. This shows that the button reacts only to falling edges and the lid only to rising edges. The AC input is held high across a status clear, which separates a level that qualifies once per high period from one that re-triggers continuously. Pulses shorter than the duration and bounces inside the window are applied, and status is sampled one cycle before and at the expected edge for each of three different durations. These checks catch an off-by-one count, a counter that is not restarted, and a duration that is shared between inputs. Enable and disable are also applied around levels that are already present and around counts in progress. These checks show that history is cleared on disable while sticky status survives it.

// File: rtl/lpwake_pkg.sv
package lpwake_pkg;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_IDLE,
        ST_COUNT,
        ST_HOLD
    } qual_state_e;

    typedef enum logic [1:0] {
        EV_FALL,
        EV_RISE,
        EV_HIGH
    } ev_kind_e;

    localparam int NUM_SRC = 3;
    localparam int NUM_WK  = 2;

endpackage

// File: rtl/lpwake_qual.sv
module lpwake_qual
    import lpwake_pkg::*;
#(
    parameter int       CNT_W = 16,
    parameter ev_kind_e KIND  = EV_FALL
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             lvl_i,
    input  logic [CNT_W-1:0] dbnc_i,
    output logic             fire_o
);

    localparam logic ACT_LVL = (KIND == EV_FALL) ? 1'b0 : 1'b1;

    qual_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             prev_q, prev_d;
    logic             trig;

    always_comb begin
        unique case (KIND)
            EV_FALL: trig = prev_q & ~lvl_i;
            EV_RISE: trig = ~prev_q & lvl_i;
            default: trig = lvl_i;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
            prev_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            prev_q  <= prev_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        prev_d  = lvl_i;
        fire_o  = 1'b0;
        if (!en_i) begin
            state_d = ST_OFF;
            cnt_d   = '0;
            prev_d  = 1'b0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end
                ST_IDLE: begin
                    if (trig) begin
                        state_d = ST_COUNT;
                        cnt_d   = '0;
                    end
                end
                ST_COUNT: begin
                    if (lvl_i != ACT_LVL) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else if (cnt_q >= dbnc_i) begin
                        fire_o  = 1'b1;
                        state_d = ST_HOLD;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                ST_HOLD: begin
                    if (lvl_i != ACT_LVL) begin
                        state_d = ST_IDLE;
                    end
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    assert_off_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (state_q == ST_OFF && cnt_q == '0))
        else $error("qualifier not cleared after disable");

    assert_bounce_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && state_q == ST_COUNT && lvl_i != ACT_LVL) |=> (cnt_q == '0 && state_q != ST_HOLD))
        else $error("bounce did not restart debounce");

    assert_fire_active_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fire_o |-> (en_i && lvl_i == ACT_LVL && state_q == ST_COUNT))
        else $error("event fired outside a valid count");

endmodule

// File: rtl/lpwake_status.sv
module lpwake_status
    import lpwake_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               en_i,
    input  logic [NUM_SRC-1:0] fire_i,
    input  logic               irq_i,
    input  logic               lp_clr_i,
    input  logic [NUM_WK-1:0]  wk_clr_i,
    output logic               lp_status_o,
    output logic [NUM_WK-1:0]  wk_status_o
);

    logic              ev_set;
    logic [NUM_WK-1:0] wk_set;

    assign ev_set = en_i & (|fire_i);
    assign wk_set = {en_i & irq_i, ev_set};

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lp_status_o <= 1'b0;
            wk_status_o <= '0;
        end else begin
            lp_status_o <= (lp_status_o & ~lp_clr_i) | ev_set;
            wk_status_o <= (wk_status_o & ~wk_clr_i) | wk_set;
        end
    end

    assert_hold_when_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i && !lp_clr_i && wk_clr_i == '0) |=>
            (lp_status_o == $past(lp_status_o) && wk_status_o == $past(wk_status_o)))
        else $error("status changed while disabled");

    assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && |fire_i) |=> (lp_status_o && wk_status_o[0]))
        else $error("accepted event did not set status");

    assert_irq_only_wk_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ev_set && !lp_clr_i) |=> (lp_status_o == $past(lp_status_o)))
        else $error("low-power status changed without an event");

endmodule

// File: rtl/lpwake_detect.sv
module lpwake_detect
    import lpwake_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             lp_en_i,
    input  logic             pwrb_i,
    input  logic             lid_i,
    input  logic             ac_i,
    input  logic [CNT_W-1:0] pwrb_dbnc_i,
    input  logic [CNT_W-1:0] lid_dbnc_i,
    input  logic [CNT_W-1:0] ac_dbnc_i,
    input  logic             irq_pend_i,
    input  logic             lp_clr_i,
    input  logic [1:0]       wk_clr_i,
    output logic             lp_status_o,
    output logic [1:0]       wk_status_o,
    output logic             wake_req_o
);

    logic [NUM_SRC-1:0] src_lvl;
    logic [NUM_SRC-1:0] src_fire;
    logic [CNT_W-1:0]   src_dbnc [NUM_SRC];

    assign src_lvl     = {ac_i, lid_i, pwrb_i};
    assign src_dbnc[0] = pwrb_dbnc_i;
    assign src_dbnc[1] = lid_dbnc_i;
    assign src_dbnc[2] = ac_dbnc_i;

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
        localparam ev_kind_e K = (gi == 0) ? EV_FALL : ((gi == 1) ? EV_RISE : EV_HIGH);
        lpwake_qual #(
            .CNT_W (CNT_W),
            .KIND  (K)
        ) u_qual (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .en_i   (lp_en_i),
            .lvl_i  (src_lvl[gi]),
            .dbnc_i (src_dbnc[gi]),
            .fire_o (src_fire[gi])
        );
    end

    lpwake_status u_status (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .en_i        (lp_en_i),
        .fire_i      (src_fire),
        .irq_i       (irq_pend_i),
        .lp_clr_i    (lp_clr_i),
        .wk_clr_i    (wk_clr_i),
        .lp_status_o (lp_status_o),
        .wk_status_o (wk_status_o)
    );

    assign wake_req_o = |wk_status_o;

    assert_req_tracks_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(wake_req_o) |-> $past(wk_clr_i != 2'b00))
        else $error("wake request dropped without a clear");

endmodule

// File: tb/lpwake_detect_tb.sv
module lpwake_detect_tb;

    localparam int CW = 16;
    localparam int D_PWRB = 6;
    localparam int D_LID  = 10;
    localparam int D_AC   = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          pwrb = 1'b1;
    logic          lid = 1'b0;
    logic          ac = 1'b0;
    logic          irq = 1'b0;
    logic          lp_clr = 1'b0;
    logic [1:0]    wk_clr = 2'b00;
    logic          lp_st;
    logic [1:0]    wk_st;
    logic          wreq;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    lpwake_detect #(.CNT_W(CW)) u_dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .lp_en_i     (en),
        .pwrb_i      (pwrb),
        .lid_i       (lid),
        .ac_i        (ac),
        .pwrb_dbnc_i (CW'(D_PWRB)),
        .lid_dbnc_i  (CW'(D_LID)),
        .ac_dbnc_i   (CW'(D_AC)),
        .irq_pend_i  (irq),
        .lp_clr_i    (lp_clr),
        .wk_clr_i    (wk_clr),
        .lp_status_o (lp_st),
        .wk_status_o (wk_st),
        .wake_req_o  (wreq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic restart();
        en = 1'b0; pwrb = 1'b1; lid = 1'b0; ac = 1'b0; irq = 1'b0;
        cyc(2);
        lp_clr = 1'b1; wk_clr = 2'b11;
        cyc(1);
        lp_clr = 1'b0; wk_clr = 2'b00;
        en = 1'b1;
        cyc(3);
    endtask

    task automatic t_reset();
        chk("R1 lp", int'(lp_st), 0);
        chk("R1 wk", int'(wk_st), 0);
        chk("R11 req at reset", int'(wreq), 0);
    endtask

    task automatic t_pwrb();
        restart();
        pwrb = 1'b0;
        cyc(D_PWRB + 1);
        chk("R5 R6 pwrb early", int'(lp_st), 0);
        cyc(1);
        chk("R2 pwrb lp", int'(lp_st), 1);
        chk("R2 pwrb wk", int'(wk_st), 1);
        chk("R11 req", int'(wreq), 1);
        restart();
        pwrb = 1'b0; cyc(1);
        en = 1'b0; cyc(2); en = 1'b1; cyc(3);
        pwrb = 1'b1;
        cyc(D_PWRB + 10);
        chk("R2 pwrb rise ignored", int'(lp_st), 0);
    endtask

    task automatic t_lid();
        restart();
        lid = 1'b1;
        cyc(D_LID + 1);
        chk("R5 R6 lid early", int'(lp_st), 0);
        cyc(1);
        chk("R3 lid lp", int'(lp_st), 1);
        chk("R3 lid wk", int'(wk_st), 1);
    endtask

    task automatic t_ac();
        restart();
        ac = 1'b1;
        cyc(D_AC + 1);
        chk("R6 ac early", int'(lp_st), 0);
        cyc(1);
        chk("R4 ac set", int'(lp_st), 1);
        lp_clr = 1'b1; wk_clr = 2'b01; cyc(1);
        lp_clr = 1'b0; wk_clr = 2'b00;
        cyc(D_AC + 10);
        chk("R4 ac no refire", int'(lp_st), 0);
        chk("R10 wk cleared", int'(wk_st), 0);
        ac = 1'b0; cyc(2);
        ac = 1'b1;
        cyc(D_AC + 2);
        chk("R4 ac second period", int'(lp_st), 1);
    endtask

    task automatic t_bounce();
        restart();
        pwrb = 1'b0; cyc(D_PWRB - 2);
        pwrb = 1'b1; cyc(2);
        pwrb = 1'b0;
        cyc(D_PWRB + 1);
        chk("R5 restart early", int'(lp_st), 0);
        cyc(1);
        chk("R5 restart set", int'(lp_st), 1);
        restart();
        lid = 1'b1; cyc(D_LID - 1);
        lid = 1'b0; cyc(D_LID + 5);
        chk("R5 short pulse", int'(lp_st), 0);
    endtask

    task automatic t_disabled();
        restart();
        en = 1'b0;
        pwrb = 1'b0; lid = 1'b1; ac = 1'b1; irq = 1'b1;
        cyc(D_AC + 5);
        chk("R7 off lp", int'(lp_st), 0);
        chk("R7 off wk", int'(wk_st), 0);
        irq = 1'b0; ac = 1'b0;
        en = 1'b1;
        cyc(D_LID + 10);
        chk("R7 present level no edge", int'(lp_st), 0);
    endtask

    task automatic t_midcount();
        restart();
        pwrb = 1'b0; cyc(3);
        en = 1'b0; cyc(2);
        en = 1'b1;
        cyc(D_PWRB + 6);
        chk("R8 count dropped", int'(lp_st), 0);
        restart();
        lid = 1'b1; cyc(D_LID + 2);
        irq = 1'b1; cyc(1); irq = 1'b0;
        en = 1'b0;
        lid = 1'b0; pwrb = 1'b0; cyc(4);
        chk("R8 lp kept", int'(lp_st), 1);
        chk("R8 wk kept", int'(wk_st), 3);
    endtask

    task automatic t_irq();
        restart();
        irq = 1'b1; cyc(1); irq = 1'b0;
        chk("R9 irq wk", int'(wk_st), 2);
        chk("R9 irq lp", int'(lp_st), 0);
        chk("R11 irq req", int'(wreq), 1);
        irq = 1'b1; wk_clr = 2'b10; cyc(1);
        irq = 1'b0; wk_clr = 2'b00;
        chk("R10 set wins", int'(wk_st), 2);
        wk_clr = 2'b10; cyc(1); wk_clr = 2'b00;
        chk("R10 clear bit1", int'(wk_st), 0);
        chk("R11 req low", int'(wreq), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        cyc(3);
        t_reset();
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_pwrb();
        t_lid();
        t_ac();
        t_bounce();
        t_disabled();
        t_midcount();
        t_irq();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule